// File: doc/BRIEF.md
# Video capture interrupt and error generator

This block sits beside the capture channels of a video input port and turns each channel's timing into interrupts for the processor. On a channel carrying embedded sync, it finds the timing reference codes in the 8-bit word stream and keeps a line count. At the start of a frame it raises a frame event, and in field mode it raises a second event at the start of the bottom field. On a channel in raw sensor mode, it raises the event when the first line of the vertically valid area begins.

An error event gathers the faults found on all channels. The receive channels check the protection bits of every code and the distance between codes against two configured lengths. The other channels report only overflow of their buffer. Each event sets a sticky status bit, which software clears with a write-one-to-clear strobe. A single-cycle pulse is sent only when the event's enable is set and its status bit was clear, so an event that arrives while an earlier one is pending is never queued.

Top module: `vcig_top`

## Requirements
- R1: After a synchronous reset, all interrupt pulses and all status bits are 0.
- R2: A timing reference code is the preamble FF, 00, 00 followed by a code word, counted in valid cycles only. In the code word, bit 7 must be 1, bit 6 is F, bit 5 is V and bit 4 is H (1 marks end of active video, 0 marks start). Bits 3 down to 0 must equal V^H, F^H, F^V and F^V^H. Any other sequence is not a code.
- R3: In embedded-sync mode the line count becomes 1 at the first end-of-active code with V=0 after one with V=1, and it advances by one on every later end-of-active code. Line 1 raises the channel's frame event. Status and pulse appear two cycles after the code word is sampled.
- R4: When the channel's field-mode input is 1, the end-of-active code that makes the line count 7 also raises the frame event. When field mode is 0, only line 1 does.
- R5: When the channel's raw-mode input is 1, the frame event fires on the first rising edge of the horizontal-valid input while vertical-valid is high, counted from vertical-valid's rising edge. A rise of both inputs in the same cycle counts.
- R6: On channels below NUM_RX, the distance is the number of valid words from the code word of one code to the first preamble word of the next, both excluded. This distance is checked when a code's H differs from the previous accepted code's H. The end-to-start distance must equal the blank length, and the start-to-end distance must equal the active length. A mismatch raises the error event.
- R7: After reset, and after a rejected code, no distance is checked until one accepted code has been seen.
- R8: On channels below NUM_RX, a code with wrong protection bits, or with bit 7 at 0, raises the error event. It is then discarded: the line count and the distance checks are not affected.
- R9: On channels at or above NUM_RX, neither protection bits nor distances are checked, and every code is accepted.
- R10: The overflow input of any channel raises the error event. The error status bit is index NCH.
- R11: Status bits are sticky. A 1 on an irq_clr bit clears that bit unless the event arrives in the same cycle, in which case the event wins.
- R12: A pulse is issued only if the event's enable bit is 1 and its status bit was 0. An event that arrives while the status bit is set sets it again but issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_word | input | NCH*8 | Word stream per channel, channel i in bits 8i+7:8i |
| ch_word_vld | input | NCH | Word valid strobe per channel |
| ch_raw_mode | input | NCH | 1 selects raw sensor sync for the frame event |
| ch_field_mode | input | NCH | 1 adds the bottom-field event at line 7 |
| raw_vvalid | input | NCH | Raw mode vertical-valid level |
| raw_hvalid | input | NCH | Raw mode horizontal-valid level |
| buf_ovf | input | NCH | Buffer overflow flag per channel |
| cfg_blank_len | input | NCH*LEN_W | Expected end-to-start distance per channel |
| cfg_active_len | input | NCH*LEN_W | Expected start-to-end distance per channel |
| irq_en | input | NCH+1 | Pulse enables, bit NCH for the error event |
| irq_clr | input | NCH+1 | Write-one-to-clear strobes for the status bits |
| frame_irq | output | NCH | Frame interrupt pulses |
| err_irq | output | 1 | Shared error interrupt pulse |
| irq_status | output | NCH+1 | Sticky status, bit NCH is the error status |

## Verification
On every cycle the assertions check the interrupt handshake. A pulse needs its enable and a clear status bit. A pulse always lands in a set status bit and never lasts two cycles. A status bit drops only after a clear strobe. Overflow always reaches the error status. Code recognition, the line count, the bottom-field rule, the raw-mode edge, the distance checks and the per-channel choice of checks all depend on the shape of the stream. Only the bench's scenarios show these, by comparing every cycle against its behavioural model.

// File: rtl/vcig_pkg.sv
package vcig_pkg;

  localparam logic [7:0] PRE_HI     = 8'hFF;
  localparam logic [7:0] PRE_LO     = 8'h00;
  localparam int         PRE_WORDS  = 3;
  localparam int         TOP_LINE   = 1;
  localparam int         BOTTOM_LINE = 7;

  typedef enum logic [1:0] {SEEK, GOT_HI, GOT_LO1, GOT_LO2} pre_st_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trc_flags_t;

  function automatic logic [3:0] prot_bits(input trc_flags_t fl);
    return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
  endfunction

endpackage

// File: rtl/vcig_trc_decode.sv
module vcig_trc_decode
  import vcig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] word,
  input  logic       word_vld,
  output logic       code_hit,
  output trc_flags_t flags,
  output logic       prot_bad
);

  pre_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (word_vld) begin
      unique case (st_q)
        SEEK:    st_d = (word == PRE_HI) ? GOT_HI : SEEK;
        GOT_HI:  st_d = (word == PRE_LO) ? GOT_LO1 : ((word == PRE_HI) ? GOT_HI : SEEK);
        GOT_LO1: st_d = (word == PRE_LO) ? GOT_LO2 : ((word == PRE_HI) ? GOT_HI : SEEK);
        default: st_d = SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEEK;
    else     st_q <= st_d;
  end

  assign code_hit = word_vld && (st_q == GOT_LO2);
  assign flags    = word[6:4];
  assign prot_bad = !word[7] || (word[3:0] != prot_bits(flags));

endmodule

// File: rtl/vcig_channel.sv
module vcig_channel
  import vcig_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int LINE_W    = 11,
  parameter bit CHECK_TRC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       word,
  input  logic             word_vld,
  input  logic             raw_mode,
  input  logic             field_mode,
  input  logic             raw_vvalid,
  input  logic             raw_hvalid,
  input  logic             buf_ovf,
  input  logic [LEN_W-1:0] cfg_blank,
  input  logic [LEN_W-1:0] cfg_active,
  output logic             frame_evt,
  output logic             err_evt
);

  localparam int               GAP_W   = LEN_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] PRE_ADJ = GAP_W'(PRE_WORDS);
  localparam logic [LINE_W-1:0] TOP_L  = LINE_W'(TOP_LINE);
  localparam logic [LINE_W-1:0] BOT_L  = LINE_W'(BOTTOM_LINE);

  logic       code_hit, prot_bad;
  trc_flags_t flags;

  vcig_trc_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .word     (word),
    .word_vld (word_vld),
    .code_hit (code_hit),
    .flags    (flags),
    .prot_bad (prot_bad)
  );

  logic [GAP_W-1:0]  gap_q;
  logic              have_prev_q, prev_h_q, last_v_q, line_ok_q;
  logic [LINE_W-1:0] line_q;
  logic              vv_q, hv_q, armed_q;

  logic             code_ok, eav_ok, top_start, bot_start, len_mis, raw_start;
  logic [GAP_W-1:0] gap_exp;
  logic             frame_d, err_d;

  always_comb begin
    code_ok   = code_hit && !(CHECK_TRC && prot_bad);
    eav_ok    = code_ok && flags.h;
    top_start = eav_ok && !flags.v && last_v_q;
    bot_start = eav_ok && !top_start && field_mode && line_ok_q &&
                ((line_q + 1'b1) == BOT_L);
    gap_exp   = (prev_h_q ? {1'b0, cfg_blank} : {1'b0, cfg_active}) + PRE_ADJ;
    len_mis   = code_ok && have_prev_q && (flags.h != prev_h_q) && (gap_q != gap_exp);
    raw_start = raw_vvalid && raw_hvalid && !hv_q && (armed_q || !vv_q);
    frame_d   = raw_mode ? raw_start : (top_start || bot_start);
    err_d     = buf_ovf || (CHECK_TRC && (len_mis || (code_hit && prot_bad)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      have_prev_q <= 1'b0;
      prev_h_q    <= 1'b0;
      last_v_q    <= 1'b0;
      line_ok_q   <= 1'b0;
      line_q      <= '0;
      vv_q        <= 1'b0;
      hv_q        <= 1'b0;
      armed_q     <= 1'b0;
      frame_evt   <= 1'b0;
      err_evt     <= 1'b0;
    end else begin
      if (code_hit)                          gap_q <= '0;
      else if (word_vld && gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;

      if (code_ok) begin
        have_prev_q <= 1'b1;
        prev_h_q    <= flags.h;
      end else if (code_hit) begin
        have_prev_q <= 1'b0;
      end

      if (eav_ok) begin
        last_v_q <= flags.v;
        if (top_start) begin
          line_ok_q <= 1'b1;
          line_q    <= TOP_L;
        end else if (line_ok_q) begin
          line_q <= line_q + 1'b1;
        end
      end

      vv_q <= raw_vvalid;
      hv_q <= raw_hvalid;
      if (raw_start)               armed_q <= 1'b0;
      else if (raw_vvalid && !vv_q) armed_q <= 1'b1;
      else if (!raw_vvalid)        armed_q <= 1'b0;

      frame_evt <= frame_d;
      err_evt   <= err_d;
    end
  end

endmodule

// File: rtl/vcig_irq_ctrl.sv
module vcig_irq_ctrl #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pulse,
  output logic [N-1:0] status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= '0;
      status <= '0;
    end else begin
      pulse  <= evt & en & ~status;
      status <= evt | (status & ~clr);
    end
  end

endmodule

// File: rtl/vcig_top.sv
module vcig_top #(
  parameter int NCH    = 4,
  parameter int NUM_RX = 2,
  parameter int LEN_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*8-1:0]   ch_word,
  input  logic [NCH-1:0]     ch_word_vld,
  input  logic [NCH-1:0]     ch_raw_mode,
  input  logic [NCH-1:0]     ch_field_mode,
  input  logic [NCH-1:0]     raw_vvalid,
  input  logic [NCH-1:0]     raw_hvalid,
  input  logic [NCH-1:0]     buf_ovf,
  input  logic [NCH*LEN_W-1:0] cfg_blank_len,
  input  logic [NCH*LEN_W-1:0] cfg_active_len,
  input  logic [NCH:0]       irq_en,
  input  logic [NCH:0]       irq_clr,
  output logic [NCH-1:0]     frame_irq,
  output logic               err_irq,
  output logic [NCH:0]       irq_status
);

  localparam int NIRQ = NCH + 1;

  logic [NCH-1:0]  frame_evt, err_evt;
  logic [NIRQ-1:0] all_evt, all_pulse;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    vcig_channel #(
      .LEN_W     (LEN_W),
      .LINE_W    (LINE_W),
      .CHECK_TRC (i < NUM_RX)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .word       (ch_word[i*8 +: 8]),
      .word_vld   (ch_word_vld[i]),
      .raw_mode   (ch_raw_mode[i]),
      .field_mode (ch_field_mode[i]),
      .raw_vvalid (raw_vvalid[i]),
      .raw_hvalid (raw_hvalid[i]),
      .buf_ovf    (buf_ovf[i]),
      .cfg_blank  (cfg_blank_len[i*LEN_W +: LEN_W]),
      .cfg_active (cfg_active_len[i*LEN_W +: LEN_W]),
      .frame_evt  (frame_evt[i]),
      .err_evt    (err_evt[i])
    );
  end

  assign all_evt = {|err_evt, frame_evt};

  vcig_irq_ctrl #(.N(NIRQ)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (all_evt),
    .en     (irq_en),
    .clr    (irq_clr),
    .pulse  (all_pulse),
    .status (irq_status)
  );

  assign frame_irq = all_pulse[NCH-1:0];
  assign err_irq   = all_pulse[NCH];

endmodule

// File: rtl/vcig_chk.sv
module vcig_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] buf_ovf,
  input logic [NCH:0]   irq_en,
  input logic [NCH:0]   irq_clr,
  input logic [NCH-1:0] frame_irq,
  input logic           err_irq,
  input logic [NCH:0]   irq_status
);

  logic [1:0] age;
  logic [NCH:0] pulses;

  assign pulses = {err_irq, frame_irq};

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R12
  pulse_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> ((pulses & $past(irq_status)) == '0));

  // R12
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> ((pulses & ~$past(irq_en)) == '0));

  // R12
  pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> ((pulses & $past(pulses)) == '0));

  // R11
  pulse_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (pulses & ~irq_status) == '0);

  // R11
  status_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |-> ((~irq_status & $past(irq_status) & ~$past(irq_clr)) == '0));

  // R10
  overflow_reaches_error_chk: assert property (@(posedge clk) disable iff (rst)
    ((age == 2'd3) && $past(|buf_ovf, 2)) |-> irq_status[NCH]);

endmodule

bind vcig_top vcig_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .buf_ovf    (buf_ovf),
  .irq_en     (irq_en),
  .irq_clr    (irq_clr),
  .frame_irq  (frame_irq),
  .err_irq    (err_irq),
  .irq_status (irq_status)
);

// File: tb/vcig_top_bench.sv
module vcig_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NUM_RX = 2;
  localparam int LEN_W = 12;
  localparam int LINE_W = 11;
  localparam int BL = 4;
  localparam int AL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH*8-1:0]     ch_word = '0;
  logic [NCH-1:0]       ch_word_vld = '0, ch_raw_mode = '0, ch_field_mode = '0;
  logic [NCH-1:0]       raw_vvalid = '0, raw_hvalid = '0, buf_ovf = '0;
  logic [NCH*LEN_W-1:0] cfg_blank_len, cfg_active_len;
  logic [NCH:0]         irq_en = '1, irq_clr = '0;
  logic [NCH-1:0]       frame_irq;
  logic                 err_irq;
  logic [NCH:0]         irq_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    assign cfg_blank_len[g*LEN_W +: LEN_W]  = LEN_W'(BL);
    assign cfg_active_len[g*LEN_W +: LEN_W] = LEN_W'(AL);
  end

  vcig_top #(.NCH(NCH), .NUM_RX(NUM_RX), .LEN_W(LEN_W), .LINE_W(LINE_W)) u_vcig_top (
    .clk(clk), .rst(rst), .ch_word(ch_word), .ch_word_vld(ch_word_vld),
    .ch_raw_mode(ch_raw_mode), .ch_field_mode(ch_field_mode),
    .raw_vvalid(raw_vvalid), .raw_hvalid(raw_hvalid), .buf_ovf(buf_ovf),
    .cfg_blank_len(cfg_blank_len), .cfg_active_len(cfg_active_len),
    .irq_en(irq_en), .irq_clr(irq_clr), .frame_irq(frame_irq),
    .err_irq(err_irq), .irq_status(irq_status)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int cnt_f[NCH];
  int cnt_e = 0;

  // behavioural reference model
  logic [NCH:0] m_evt = '0, m_pulse = '0, m_status = '0;
  int hist[NCH][3];
  int hcnt[NCH], gap[NCH], line[NCH];
  bit have[NCH], prv_h[NCH], lastv[NCH], lok[NCH], vvq[NCH], hvq[NCH], armed[NCH];

  always @(posedge clk) begin
    if (rst) begin
      m_evt = '0; m_pulse = '0; m_status = '0;
      for (int c = 0; c < NCH; c++) begin
        hcnt[c] = 0; gap[c] = 0; line[c] = 0; have[c] = 0; prv_h[c] = 0;
        lastv[c] = 0; lok[c] = 0; vvq[c] = 0; hvq[c] = 0; armed[c] = 0;
      end
    end else begin
      bit e_any;
      for (int i = 0; i <= NCH; i++) begin
        m_pulse[i]  = m_evt[i] && irq_en[i] && !m_status[i];
        m_status[i] = m_evt[i] || (m_status[i] && !irq_clr[i]);
      end
      e_any = 0;
      for (int c = 0; c < NCH; c++) begin
        bit fe_t, ee, rs, rv;
        logic [7:0] w;
        fe_t = 0;
        ee = buf_ovf[c];
        if (ch_word_vld[c]) begin
          w = ch_word[c*8 +: 8];
          if (hcnt[c] >= 3 && hist[c][0] == 255 && hist[c][1] == 0 && hist[c][2] == 0) begin
            bit f, v, h, bad, chk;
            f = w[6]; v = w[5]; h = w[4];
            bad = !w[7] || (w[3:0] != {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
            chk = (c < NUM_RX);
            hcnt[c] = 0;
            if (chk && bad) begin
              ee = 1; have[c] = 0;
            end else begin
              if (chk && have[c] && h != prv_h[c])
                if (gap[c] - 3 != (prv_h[c] ? BL : AL)) ee = 1;
              have[c] = 1; prv_h[c] = h;
              if (h) begin
                if (!v && lastv[c]) begin line[c] = 1; lok[c] = 1; fe_t = 1; end
                else if (lok[c]) begin
                  line[c]++;
                  if (ch_field_mode[c] && line[c] == 7) fe_t = 1;
                end
                lastv[c] = v;
              end
            end
            gap[c] = 0;
          end else begin
            hist[c][0] = hist[c][1]; hist[c][1] = hist[c][2]; hist[c][2] = int'(w);
            hcnt[c]++; gap[c]++;
          end
        end
        rv = raw_vvalid[c] && !vvq[c];
        rs = raw_vvalid[c] && raw_hvalid[c] && !hvq[c] && (armed[c] || rv);
        if (rs) armed[c] = 0; else if (rv) armed[c] = 1; else if (!raw_vvalid[c]) armed[c] = 0;
        vvq[c] = raw_vvalid[c]; hvq[c] = raw_hvalid[c];
        m_evt[c] = ch_raw_mode[c] ? rs : fe_t;
        e_any = e_any || ee;
      end
      m_evt[NCH] = e_any;
    end
  end

  // per-cycle comparison and pulse counting
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if ({err_irq, frame_irq} !== m_pulse || irq_status !== m_status) begin
        n_fail++;
        $display("FAIL %s: pulses=%b status=%b expected pulses=%b status=%b",
                 cur_req, {err_irq, frame_irq}, irq_status, m_pulse, m_status);
      end
      for (int i = 0; i < NCH; i++) cnt_f[i] += int'(frame_irq[i]);
      cnt_e += int'(err_irq);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ch_word_vld = '0; buf_ovf = '0; irq_clr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); quiet(); end
  endtask

  task automatic put(int ch, logic [7:0] w);
    @(negedge clk); quiet();
    ch_word[ch*8 +: 8] = w;
    ch_word_vld[ch] = 1'b1;
  endtask

  task automatic send_code(int ch, bit f, bit v, bit h, bit bad);
    logic [3:0] p;
    p = {v ^ h, f ^ h, f ^ v, f ^ v ^ h} ^ {3'b000, bad};
    put(ch, 8'hFF); put(ch, 8'h00); put(ch, 8'h00);
    put(ch, {1'b1, f, v, h, p});
  endtask

  task automatic send_fill(int ch, int n, logic [7:0] w);
    for (int k = 0; k < n; k++) begin
      put(ch, w);
      if (k % 3 == 2) idle(1);
    end
  endtask

  task automatic send_line(int ch, bit v, int bl, int al, bit bad);
    send_code(ch, 1'b0, v, 1'b1, bad);
    send_fill(ch, bl, 8'h10);
    send_code(ch, 1'b0, v, 1'b0, 1'b0);
    send_fill(ch, al, 8'h80);
    idle(1);
  endtask

  task automatic clear_all();
    @(negedge clk); quiet(); irq_clr = '1;
    @(negedge clk); quiet();
  endtask

  task automatic ovf_pulse(int ch);
    @(negedge clk); quiet(); buf_ovf[ch] = 1'b1;
    @(negedge clk); quiet();
  endtask

  task automatic do_reset();
    @(negedge clk); quiet(); rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int b;
    for (int i = 0; i < NCH; i++) cnt_f[i] = 0;
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check("R1", int'(irq_status), 0);
    check("R1", int'({err_irq, frame_irq}), 0);

    // frame event at line 1
    cur_req = "R3";
    b = cnt_f[0];
    send_line(0, 1, BL, AL, 0); send_line(0, 1, BL, AL, 0);
    for (int l = 0; l < 3; l++) send_line(0, 0, BL, AL, 0);
    idle(3);
    check("R3", cnt_f[0] - b, 1);
    check("R3", int'(irq_status[0]), 1);
    check("R6", int'(irq_status[NCH]), 0);

    // near-miss preambles on an unchecked channel
    cur_req = "R2";
    clear_all();
    b = cnt_f[3];
    send_line(3, 1, BL, AL, 0);
    put(3, 8'hFF); put(3, 8'h00); put(3, 8'h10); put(3, 8'h9D);
    put(3, 8'hFF); put(3, 8'hFF); put(3, 8'h00); put(3, 8'h00);
    put(3, 8'h9D);
    send_fill(3, 4, 8'h10);
    send_code(3, 0, 0, 0, 0);
    idle(3);
    check("R2", cnt_f[3] - b, 1);

    // field mode versus frame mode
    cur_req = "R4";
    clear_all();
    ch_field_mode[1] = 1'b1;
    b = cnt_f[1];
    send_line(1, 1, BL, AL, 0);
    for (int l = 1; l <= 8; l++) begin
      send_line(1, 0, BL, AL, 0);
      if (l == 3) clear_all();
    end
    idle(3);
    check("R4", cnt_f[1] - b, 2);
    b = cnt_f[0];
    send_line(0, 1, BL, AL, 0);
    for (int l = 1; l <= 8; l++) begin
      send_line(0, 0, BL, AL, 0);
      if (l == 3) clear_all();
    end
    idle(3);
    check("R4", cnt_f[0] - b, 1);

    // raw sensor mode
    cur_req = "R5";
    clear_all();
    ch_raw_mode[2] = 1'b1;
    b = cnt_f[2];
    for (int fr = 0; fr < 2; fr++) begin
      @(negedge clk); quiet(); raw_vvalid[2] = 1'b0; raw_hvalid[2] = 1'b1;
      idle(2);
      @(negedge clk); quiet(); raw_vvalid[2] = 1'b1;
      idle(2);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); quiet(); raw_hvalid[2] = 1'b0;
        @(negedge clk); quiet(); raw_hvalid[2] = 1'b1;
      end
      idle(3);
      clear_all();
    end
    check("R5", cnt_f[2] - b, 2);
    raw_vvalid[2] = 1'b0; raw_hvalid[2] = 1'b0; ch_raw_mode[2] = 1'b0;

    // distance checks
    cur_req = "R6";
    b = cnt_e;
    send_line(0, 0, BL + 1, AL, 0);
    idle(3);
    check("R6", int'(irq_status[NCH]), 1);
    check("R6", cnt_e - b, 1);
    clear_all();
    send_line(0, 0, BL, AL - 1, 0);
    send_line(0, 0, BL, AL, 0);
    idle(3);
    check("R6", int'(irq_status[NCH]), 1);
    clear_all();
    send_line(0, 0, BL, AL, 0); send_line(0, 0, BL, AL, 0);
    idle(3);
    check("R6", int'(irq_status[NCH]), 0);

    // no check before the first accepted code
    cur_req = "R7";
    do_reset();
    send_fill(0, 5, 8'h10);
    send_code(0, 0, 0, 0, 0);
    send_fill(0, AL, 8'h80);
    send_line(0, 0, BL, AL, 0);
    idle(3);
    check("R7", int'(irq_status[NCH]), 0);

    // bad protection on a checked channel
    cur_req = "R8";
    b = cnt_e;
    send_code(0, 0, 0, 1, 1);
    send_fill(0, BL + 5, 8'h10);
    send_code(0, 0, 0, 0, 0);
    send_fill(0, AL, 8'h80);
    send_line(0, 0, BL, AL, 0);
    idle(3);
    check("R8", cnt_e - b, 1);
    check("R7", int'(irq_status[NCH]), 1);
    clear_all();

    // unchecked channel ignores protection and distance faults
    cur_req = "R9";
    b = cnt_e;
    send_line(3, 0, BL - 2, AL + 3, 1);
    send_line(3, 0, BL, AL, 0);
    idle(3);
    check("R9", cnt_e - b, 0);
    check("R9", int'(irq_status[NCH]), 0);

    // overflow
    cur_req = "R10";
    ovf_pulse(3);
    idle(3);
    check("R10", int'(irq_status[NCH]), 1);
    clear_all();
    b = cnt_e;
    ovf_pulse(0);
    idle(3);
    check("R10", cnt_e - b, 1);

    // event wins over clear
    cur_req = "R11";
    @(negedge clk); quiet(); buf_ovf[2] = 1'b1;
    @(negedge clk); quiet(); irq_clr = '1;
    idle(3);
    check("R11", int'(irq_status[NCH]), 1);
    clear_all();
    idle(2);
    check("R11", int'(irq_status), 0);

    // enable gating and no re-issue
    cur_req = "R12";
    irq_en[NCH] = 1'b0;
    b = cnt_e;
    ovf_pulse(1);
    idle(3);
    check("R12", cnt_e - b, 0);
    check("R12", int'(irq_status[NCH]), 1);
    irq_en[NCH] = 1'b1;
    ovf_pulse(1);
    idle(3);
    check("R12", cnt_e - b, 0);
    clear_all();
    ovf_pulse(1);
    idle(3);
    check("R12", cnt_e - b, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule